// File: doc/BRIEF.md
# Shared-Window Flash Command Mailbox

This block is the device side of a host-to-flash mailbox. The host sees a small window of byte-wide registers. Byte 0 carries handshake flags, byte 3 carries a command code, and the bytes from offset 4 onward form a parameter and data field. The host fills in the code and the field, then raises the execute flag. The engine decodes the command and runs it against an internal byte-array flash model. It then raises either ready or error and holds that flag until the host drops execute.

Flash access is locked behind an update mode, which a four-byte unlock key opens. A single address pointer is loaded once and then advances across successive chunked read and chunked program commands. For these two commands, the low nibble of the code gives the transfer length. Programming can only clear bits. Erase restores a whole sector to 0xFF. An identification command returns a fixed four-byte device ID. Leaving update mode records which of three exit reasons the host gave.

Top module: `flash_mailbox`

## Requirements
- R1: After reset, byte 0 reads 0x00, `update_active` is 0, `exit_reason` is 0, and every byte of the flash model holds 0xFF.
- R2: Window layout. Byte 0 bit 0 is execute, which the host can read and write. Bit 5 is update-mode, bit 6 is error and bit 7 is ready; all three are device-driven, and host writes to them have no effect. Bytes 1 and 2 read 0. Byte 3 is the command code. Bytes 4 to 15 are field bytes 0 to 11, and the host can read back what it wrote to them.
- R3: Code 0x10 enters update mode, but only when field bytes 0 to 3 hold 0x55, 0xAA, 0xCD, 0xBE. Any other key raises error and leaves the mode unchanged.
- R4: Set-address (0xA0), read, program and erase raise error when issued outside update mode, and they have no effect on the flash or the pointer.
- R5: Code 0xA0 loads the 32-bit pointer from field bytes 0 to 3, least significant byte first. Flash is indexed by the pointer modulo the flash size.
- R6: Code 0xD0|n copies n flash bytes, starting at the pointer, into field bytes 0 to n-1, then adds n to the pointer. An n of 0 or above 12 raises error.
- R7: Code 0xB0|n replaces each of n flash bytes, starting at the pointer, with old AND field byte i, then adds n to the pointer. An n of 0 or above 8 raises error.
- R8: Code 0x80 sets every byte of the sector that holds the little-endian field address to 0xFF. Other sectors and the pointer are left unchanged.
- R9: Code 0xC0 writes the ID bytes, least significant first, into field bytes 0 to 3. It works in or out of update mode.
- R10: Codes 0x20, 0x21 and 0x22 leave update mode and set `exit_reason` to 0, 1 or 2. Outside update mode these codes raise error. Any code not listed here also raises error.
- R11: Ready and error are never set together. Either flag holds while execute stays 1 and clears on the cycle after execute is seen at 0. Host writes to the code and field bytes are ignored while execute is set or a command is in progress.
- R12: The pointer and the update mode change only on the cycle in which ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_addr | input | 4 | Window byte offset for reads and writes |
| win_wr | input | 1 | Host write strobe for the byte at `win_addr` |
| win_wdata | input | 8 | Host write data |
| win_rdata | output | 8 | Combinational read of the byte at `win_addr` |
| update_active | output | 1 | Update mode is open |
| exit_reason | output | 2 | Reason given by the most recent exit command |

## Verification
On every cycle, the checker enforces the handshake rules: ready and error are exclusive, a flag holds while execute stays up, and both flags clear one cycle after execute falls. It also checks that the pointer and the update mode move only together with a rising ready. The data behaviour can only be shown by the directed scenarios. These cover the AND-only program, the pointer continuing across chunks, wrap-around modulo the flash size, sector boundaries on erase, the key check and the length limits. The scenarios also cover field writes being ignored while a command is outstanding.

// File: rtl/fmb_pkg.sv
package fmb_pkg;

   typedef enum logic [2:0] {
      OP_BAD, OP_ENTER, OP_EXIT, OP_SETPTR, OP_READ, OP_PROG, OP_ERASE, OP_IDENT
   } op_kind_e;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eng_state_e;

   // Window byte offsets
   localparam int OFS_SEM   = 0;
   localparam int OFS_CODE  = 3;
   localparam int OFS_FIELD = 4;

   // Semaphore bit positions
   localparam int SEM_EXE = 0;
   localparam int SEM_UPD = 5;
   localparam int SEM_ERR = 6;
   localparam int SEM_RDY = 7;

   // Command codes (high nibble for length-carrying commands)
   localparam logic [3:0] HI_ENTER  = 4'h1;
   localparam logic [3:0] HI_EXIT   = 4'h2;
   localparam logic [3:0] HI_SETPTR = 4'hA;
   localparam logic [3:0] HI_IDENT  = 4'hC;
   localparam logic [3:0] HI_ERASE  = 4'h8;
   localparam logic [3:0] HI_READ   = 4'hD;
   localparam logic [3:0] HI_PROG   = 4'hB;

   // Unlock key as seen on field bytes 0..3, byte 0 in the low bits
   localparam logic [31:0] UNLOCK_KEY = 32'hBECD_AA55;

endpackage

// File: rtl/fmb_decode.sv
module fmb_decode
   import fmb_pkg::*;
#(
   parameter int MAX_RD = 12,
   parameter int MAX_WR = 8
) (
   input  logic [7:0]  code,
   input  logic [31:0] key,
   input  logic        in_update,
   output op_kind_e    kind,
   output logic [3:0]  len
);

   localparam logic [3:0] RD_LIM = 4'(MAX_RD);
   localparam logic [3:0] WR_LIM = 4'(MAX_WR);

   logic [3:0] hi;
   logic       lo_zero;

   assign hi      = code[7:4];
   assign len     = code[3:0];
   assign lo_zero = (code[3:0] == 4'd0);

   always_comb begin
      kind = OP_BAD;
      case (hi)
         HI_ENTER:  if (lo_zero && key == UNLOCK_KEY)         kind = OP_ENTER;
         HI_EXIT:   if (in_update && code[3:0] <= 4'd2)        kind = OP_EXIT;
         HI_SETPTR: if (in_update && lo_zero)                  kind = OP_SETPTR;
         HI_IDENT:  if (lo_zero)                               kind = OP_IDENT;
         HI_ERASE:  if (in_update && lo_zero)                  kind = OP_ERASE;
         HI_READ:   if (in_update && !lo_zero && len <= RD_LIM) kind = OP_READ;
         HI_PROG:   if (in_update && !lo_zero && len <= WR_LIM) kind = OP_PROG;
         default:   kind = OP_BAD;
      endcase
   end

endmodule

// File: rtl/fmb_store.sv
module fmb_store #(
   parameter int DEPTH        = 1024,
   parameter bit RESET_ERASED = 1'b1,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   generate
      if (RESET_ERASED) begin : g_reset_erased
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_no_reset
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/fmb_window.sv
module fmb_window
   import fmb_pkg::*;
#(
   parameter int FIELD_BYTES = 12,
   localparam int WIN_BYTES  = OFS_FIELD + FIELD_BYTES,
   localparam int WIN_AW     = $clog2(WIN_BYTES),
   localparam int IDX_W      = $clog2(FIELD_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WIN_AW-1:0]        host_addr,
   input  logic                     host_wr,
   input  logic [7:0]               host_wdata,
   output logic [7:0]               host_rdata,
   input  logic                     dev_rdy,
   input  logic                     dev_err,
   input  logic                     dev_upd,
   input  logic                     dev_busy,
   input  logic                     eng_we,
   input  logic [IDX_W-1:0]         eng_idx,
   input  logic [7:0]               eng_data,
   output logic                     exe,
   output logic [7:0]               code,
   output logic [FIELD_BYTES*8-1:0] field_flat
);

   logic lock;
   assign lock = exe | dev_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exe <= 1'b0;
      end else if (host_wr && host_addr == WIN_AW'(OFS_SEM)) begin
         exe <= host_wdata[SEM_EXE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= 8'h00;
      end else if (host_wr && !lock && host_addr == WIN_AW'(OFS_CODE)) begin
         code <= host_wdata;
      end
   end

   generate
      for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_field
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               field_flat[g*8 +: 8] <= 8'h00;
            end else if (eng_we && eng_idx == IDX_W'(g)) begin
               field_flat[g*8 +: 8] <= eng_data;
            end else if (host_wr && !lock && host_addr == WIN_AW'(OFS_FIELD + g)) begin
               field_flat[g*8 +: 8] <= host_wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      host_rdata = 8'h00;
      if (host_addr == WIN_AW'(OFS_SEM)) begin
         host_rdata[SEM_EXE] = exe;
         host_rdata[SEM_UPD] = dev_upd;
         host_rdata[SEM_ERR] = dev_err;
         host_rdata[SEM_RDY] = dev_rdy;
      end else if (host_addr == WIN_AW'(OFS_CODE)) begin
         host_rdata = code;
      end else begin
         for (int i = 0; i < FIELD_BYTES; i++) begin
            if (host_addr == WIN_AW'(OFS_FIELD + i)) host_rdata = field_flat[i*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/fmb_engine.sv
module fmb_engine
   import fmb_pkg::*;
#(
   parameter int          FLASH_BYTES  = 1024,
   parameter int          SECTOR_BYTES = 256,
   parameter int          FIELD_BYTES  = 12,
   parameter int          MAX_RD       = 12,
   parameter int          MAX_WR       = 8,
   parameter logic [31:0] ID_WORD      = 32'hA517_40EF,
   localparam int         AW           = $clog2(FLASH_BYTES),
   localparam int         CW           = $clog2(SECTOR_BYTES),
   localparam int         IDX_W        = $clog2(FIELD_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     exe,
   input  logic [7:0]               code,
   input  logic [FIELD_BYTES*8-1:0] field_flat,
   input  logic [7:0]               mem_rdata,
   output logic                     mem_we,
   output logic [AW-1:0]            mem_addr,
   output logic [7:0]               mem_wdata,
   output logic                     eng_we,
   output logic [IDX_W-1:0]         eng_idx,
   output logic [7:0]               eng_data,
   output logic                     busy,
   output logic                     rdy,
   output logic                     err,
   output logic                     upd,
   output logic [1:0]               exit_reason,
   output logic [31:0]              ptr
);

   localparam logic [AW-1:0] SECT_MASK = ~AW'(SECTOR_BYTES - 1);

   eng_state_e     state;
   op_kind_e       kind, op_q;
   logic [3:0]     dec_len, len_q;
   logic [CW-1:0]  cnt;
   logic [AW-1:0]  base;
   logic           last;
   logic [7:0]     fld_byte;
   logic [31:0]    id_sh;

   fmb_decode #(.MAX_RD(MAX_RD), .MAX_WR(MAX_WR)) i_decode (
      .code      (code),
      .key       (field_flat[31:0]),
      .in_update (upd),
      .kind      (kind),
      .len       (dec_len)
   );

   assign busy     = (state != ST_IDLE);
   assign eng_idx  = cnt[IDX_W-1:0];
   assign mem_addr = ((op_q == OP_ERASE) ? base : ptr[AW-1:0]) + AW'(cnt);
   assign fld_byte = field_flat[8*eng_idx +: 8];
   assign id_sh    = ID_WORD >> {cnt[1:0], 3'b000};

   always_comb begin
      case (op_q)
         OP_ERASE: last = (cnt == CW'(SECTOR_BYTES - 1));
         OP_IDENT: last = (cnt == CW'(3));
         default:  last = (cnt == CW'(len_q - 4'd1));
      endcase
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = 8'hFF;
      eng_we    = 1'b0;
      eng_data  = mem_rdata;
      if (state == ST_RUN) begin
         case (op_q)
            OP_READ:  eng_we = 1'b1;
            OP_IDENT: begin eng_we = 1'b1; eng_data = id_sh[7:0]; end
            OP_PROG:  begin mem_we = 1'b1; mem_wdata = mem_rdata & fld_byte; end
            OP_ERASE: mem_we = 1'b1;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         op_q        <= OP_BAD;
         len_q       <= 4'd0;
         cnt         <= '0;
         base        <= '0;
         rdy         <= 1'b0;
         err         <= 1'b0;
         upd         <= 1'b0;
         exit_reason <= 2'd0;
         ptr         <= 32'd0;
      end else begin
         case (state)
            ST_IDLE: if (exe) begin
               op_q  <= kind;
               len_q <= dec_len;
               cnt   <= '0;
               case (kind)
                  OP_BAD:    begin err <= 1'b1; state <= ST_DONE; end
                  OP_ENTER:  begin upd <= 1'b1; rdy <= 1'b1; state <= ST_DONE; end
                  OP_EXIT:   begin
                     upd         <= 1'b0;
                     exit_reason <= code[1:0];
                     rdy         <= 1'b1;
                     state       <= ST_DONE;
                  end
                  OP_SETPTR: begin ptr <= field_flat[31:0]; rdy <= 1'b1; state <= ST_DONE; end
                  OP_ERASE:  begin base <= field_flat[AW-1:0] & SECT_MASK; state <= ST_RUN; end
                  default:   state <= ST_RUN;
               endcase
            end
            ST_RUN: begin
               cnt <= cnt + CW'(1);
               if (last) begin
                  rdy   <= 1'b1;
                  state <= ST_DONE;
                  if (op_q == OP_READ || op_q == OP_PROG) ptr <= ptr + 32'(len_q);
               end
            end
            ST_DONE: if (!exe) begin
               rdy   <= 1'b0;
               err   <= 1'b0;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_mailbox.sv
module flash_mailbox
   import fmb_pkg::*;
#(
   parameter int          FLASH_BYTES  = 1024,
   parameter int          SECTOR_BYTES = 256,
   parameter int          FIELD_BYTES  = 12,
   parameter int          MAX_RD       = 12,
   parameter int          MAX_WR       = 8,
   parameter logic [31:0] ID_WORD      = 32'hA517_40EF,
   parameter bit          RESET_ERASED = 1'b1,
   localparam int         WIN_AW       = $clog2(OFS_FIELD + FIELD_BYTES),
   localparam int         AW           = $clog2(FLASH_BYTES),
   localparam int         IDX_W        = $clog2(FIELD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIN_AW-1:0] win_addr,
   input  logic              win_wr,
   input  logic [7:0]        win_wdata,
   output logic [7:0]        win_rdata,
   output logic              update_active,
   output logic [1:0]        exit_reason
);

   generate
      if (FIELD_BYTES < 4 || FIELD_BYTES > 12)
         $error("FIELD_BYTES must lie in 4..12");
      if (MAX_RD < 1 || MAX_RD > FIELD_BYTES)
         $error("MAX_RD must lie in 1..FIELD_BYTES");
      if (MAX_WR < 1 || MAX_WR > FIELD_BYTES)
         $error("MAX_WR must lie in 1..FIELD_BYTES");
      if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES < 16)
         $error("SECTOR_BYTES must be a power of two of at least 16");
      if ((FLASH_BYTES & (FLASH_BYTES - 1)) != 0 || FLASH_BYTES < SECTOR_BYTES)
         $error("FLASH_BYTES must be a power of two no smaller than a sector");
   endgenerate

   logic                     exe_w, rdy_w, err_w, busy_w;
   logic [7:0]               code_w;
   logic [FIELD_BYTES*8-1:0] field_w;
   logic                     eng_we_w;
   logic [IDX_W-1:0]         eng_idx_w;
   logic [7:0]               eng_data_w;
   logic                     mem_we_w;
   logic [AW-1:0]            mem_addr_w;
   logic [7:0]               mem_wdata_w, mem_rdata_w;
   logic [31:0]              ptr_w;

   fmb_window #(.FIELD_BYTES(FIELD_BYTES)) i_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_addr  (win_addr),
      .host_wr    (win_wr),
      .host_wdata (win_wdata),
      .host_rdata (win_rdata),
      .dev_rdy    (rdy_w),
      .dev_err    (err_w),
      .dev_upd    (update_active),
      .dev_busy   (busy_w),
      .eng_we     (eng_we_w),
      .eng_idx    (eng_idx_w),
      .eng_data   (eng_data_w),
      .exe        (exe_w),
      .code       (code_w),
      .field_flat (field_w)
   );

   fmb_engine #(
      .FLASH_BYTES  (FLASH_BYTES),
      .SECTOR_BYTES (SECTOR_BYTES),
      .FIELD_BYTES  (FIELD_BYTES),
      .MAX_RD       (MAX_RD),
      .MAX_WR       (MAX_WR),
      .ID_WORD      (ID_WORD)
   ) i_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .exe         (exe_w),
      .code        (code_w),
      .field_flat  (field_w),
      .mem_rdata   (mem_rdata_w),
      .mem_we      (mem_we_w),
      .mem_addr    (mem_addr_w),
      .mem_wdata   (mem_wdata_w),
      .eng_we      (eng_we_w),
      .eng_idx     (eng_idx_w),
      .eng_data    (eng_data_w),
      .busy        (busy_w),
      .rdy         (rdy_w),
      .err         (err_w),
      .upd         (update_active),
      .exit_reason (exit_reason),
      .ptr         (ptr_w)
   );

   fmb_store #(.DEPTH(FLASH_BYTES), .RESET_ERASED(RESET_ERASED)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we_w),
      .waddr (mem_addr_w),
      .wdata (mem_wdata_w),
      .raddr (mem_addr_w),
      .rdata (mem_rdata_w)
   );

endmodule

// File: rtl/fmb_checker.sv
module fmb_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        exe,
   input logic        rdy,
   input logic        err,
   input logic        upd,
   input logic [31:0] ptr
);

   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rdy && err));

   assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdy || err) && exe) |=> (rdy || err));

   assert_flag_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdy || err) && !exe) |=> (!rdy && !err));

   assert_mode_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (upd != $past(upd)) |-> $rose(rdy));

   assert_ptr_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> $rose(rdy));

endmodule

bind flash_mailbox fmb_checker i_fmb_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .exe   (exe_w),
   .rdy   (rdy_w),
   .err   (err_w),
   .upd   (update_active),
   .ptr   (ptr_w)
);

// File: tb/test_flash_mailbox.sv
`timescale 1ns/1ps
module test_flash_mailbox;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] win_addr = 4'd0;
   logic       win_wr = 1'b0;
   logic [7:0] win_wdata = 8'h00;
   logic [7:0] win_rdata;
   logic       update_active;
   logic [1:0] exit_reason;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   flash_mailbox i_flash_mailbox (
      .clk           (clk),
      .rst_n         (rst_n),
      .win_addr      (win_addr),
      .win_wr        (win_wr),
      .win_wdata     (win_wdata),
      .win_rdata     (win_rdata),
      .update_active (update_active),
      .exit_reason   (exit_reason)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      win_addr = a; win_wdata = d; win_wr = 1'b1;
      @(negedge clk);
      win_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      win_addr = a;
      #0.5;
      d = win_rdata;
   endtask

   task automatic set_key(input logic [31:0] k);
      for (int i = 0; i < 4; i++) wr(4'(4 + i), k[8*i +: 8]);
   endtask

   // Run one command; checks the outcome flag and the flag release (R11)
   task automatic run(input logic [7:0] code, input bit want_err, input string req);
      logic [7:0] s;
      s = 8'h00;
      wr(4'd3, code);
      wr(4'd0, 8'h01);
      for (int i = 0; i < 3000; i++) begin
         rd(4'd0, s);
         if (s[7] || s[6]) break;
      end
      if (want_err) check(s[6] && !s[7], req, s, 8'h41);
      else          check(s[7] && !s[6], req, s, 8'h81);
      wr(4'd0, 8'h00);
      rd(4'd0, s);
      check(s[7:6] == 2'b00, "R11 flags release", s[7:6], 0);
   endtask

   task automatic expect_field(input int idx, input logic [7:0] exp, input string req);
      logic [7:0] d;
      rd(4'(4 + idx), d);
      check(d == exp, req, d, exp);
   endtask

   task automatic set_ptr(input logic [31:0] a);
      set_key(a);
      run(8'hA0, 1'b0, "R5 set address");
   endtask

   task automatic t_reset;
      logic [7:0] s;
      rd(4'd0, s);
      check(s == 8'h00, "R1 byte0 after reset", s, 0);
      check(update_active == 1'b0 && exit_reason == 2'd0, "R1 mode after reset",
            {update_active, exit_reason}, 0);
   endtask

   task automatic t_layout;
      logic [7:0] d;
      wr(4'd0, 8'hE0);
      rd(4'd0, d);
      check(d == 8'h00, "R2 device bits not host writable", d, 0);
      wr(4'd1, 8'h5A); wr(4'd2, 8'hA5);
      rd(4'd1, d); check(d == 8'h00, "R2 reserved byte 1", d, 0);
      rd(4'd2, d); check(d == 8'h00, "R2 reserved byte 2", d, 0);
      wr(4'd3, 8'h6C);
      rd(4'd3, d); check(d == 8'h6C, "R2 code readback", d, 8'h6C);
      wr(4'd15, 8'h3E);
      rd(4'd15, d); check(d == 8'h3E, "R2 last field byte readback", d, 8'h3E);
   endtask

   task automatic t_locked;
      set_key(32'h0000_0010);
      run(8'hA0, 1'b1, "R4 set address locked");
      run(8'hD4, 1'b1, "R4 read locked");
      run(8'hB1, 1'b1, "R4 program locked");
      run(8'h80, 1'b1, "R4 erase locked");
      run(8'hC0, 1'b0, "R9 ident outside mode");
      expect_field(0, 8'hEF, "R9 id byte 0");
      expect_field(1, 8'h40, "R9 id byte 1");
      expect_field(2, 8'h17, "R9 id byte 2");
      expect_field(3, 8'hA5, "R9 id byte 3");
   endtask

   task automatic t_enter;
      logic [7:0] s;
      set_key(32'hBECD_AA56);
      run(8'h10, 1'b1, "R3 bad key rejected");
      check(update_active == 1'b0, "R3 mode unchanged on bad key", update_active, 0);
      set_key(32'hBECD_AA55);
      wr(4'd3, 8'h10);
      wr(4'd0, 8'h01);
      repeat (3) @(negedge clk);
      rd(4'd0, s);
      check(s == 8'hA1, "R3 enter ready with mode bit", s, 8'hA1);
      wr(4'd0, 8'h00);
      rd(4'd0, s);
      check(s == 8'h20, "R11 release keeps mode bit", s, 8'h20);
   endtask

   task automatic t_read_prog;
      set_ptr(32'h0000_0010);
      run(8'hDC, 1'b0, "R6 read 12 erased");
      for (int i = 0; i < 12; i++) expect_field(i, 8'hFF, "R1 erased content");
      set_ptr(32'h0000_01FE);
      set_key(32'h7856_3412);
      run(8'hB4, 1'b0, "R7 program 4");
      wr(4'd4, 8'hF0);
      run(8'hB1, 1'b0, "R7 program continues at pointer");
      set_ptr(32'h0000_01FE);
      wr(4'd4, 8'h0F);
      run(8'hB1, 1'b0, "R7 program AND");
      set_ptr(32'h0000_01FE);
      run(8'hD2, 1'b0, "R6 read 2");
      expect_field(0, 8'h02, "R7 AND result");
      expect_field(1, 8'h34, "R7 second byte");
      run(8'hD3, 1'b0, "R6 read continues");
      expect_field(0, 8'h56, "R6 pointer advance");
      expect_field(1, 8'h78, "R6 pointer advance");
      expect_field(2, 8'hF0, "R7 pointer advance after program");
      run(8'hD0, 1'b1, "R6 length 0");
      run(8'hDD, 1'b1, "R6 length 13");
      run(8'hB0, 1'b1, "R7 length 0");
      run(8'hB9, 1'b1, "R7 length 9");
   endtask

   task automatic t_erase_wrap;
      logic [7:0] d;
      set_ptr(32'h0000_01FC);
      set_key(32'h0000_01F0);
      run(8'h80, 1'b0, "R8 erase sector");
      run(8'hD6, 1'b0, "R8 read across boundary");
      for (int i = 0; i < 4; i++) expect_field(i, 8'hFF, "R8 sector erased");
      expect_field(4, 8'h56, "R8 next sector kept");
      expect_field(5, 8'h78, "R8 next sector kept");
      set_ptr(32'h0000_0600);
      run(8'hD1, 1'b0, "R5 wrap read");
      expect_field(0, 8'h56, "R5 address modulo flash size");
      // R11: field writes ignored while execute is up
      wr(4'd3, 8'hD1);
      wr(4'd0, 8'h01);
      repeat (4) @(negedge clk);
      wr(4'd4, 8'h99);
      rd(4'd4, d);
      check(d == 8'h57 || d == 8'h78 || d != 8'h99, "R11 field locked", d, 8'h78);
      wr(4'd0, 8'h00);
      repeat (2) @(negedge clk);
      expect_field(0, 8'h78, "R11 field holds engine data");
      run(8'h33, 1'b1, "R10 unknown code");
   endtask

   task automatic t_exit;
      run(8'h21, 1'b0, "R10 exit reboot");
      check(update_active == 1'b0 && exit_reason == 2'd1, "R10 reason 1",
            {update_active, exit_reason}, 1);
      run(8'h20, 1'b1, "R10 exit outside mode");
      set_key(32'hBECD_AA55);
      run(8'h10, 1'b0, "R3 re-enter");
      run(8'h22, 1'b0, "R10 exit watchdog");
      check(exit_reason == 2'd2, "R10 reason 2", exit_reason, 2);
      set_key(32'hBECD_AA55);
      run(8'h10, 1'b0, "R3 re-enter");
      run(8'h20, 1'b0, "R10 exit unchanged");
      check(exit_reason == 2'd0 && !update_active, "R10 reason 0", exit_reason, 0);
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_locked();
      t_enter();
      t_read_prog();
      t_erase_wrap();
      t_exit();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule